// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Fill Flags

This block is a synchronous first-in first-out buffer. It sits on one clock. Storage is a plain dual-port memory array, and all pointer, occupancy and flag logic is ordinary logic around that array. Words are pushed with `wr_en` and popped with `rd_en`. Four registered status outputs report the fill level: `full`, `empty`, `almost_full` and `almost_empty`. The two almost thresholds are build-time parameters. Each one is an absolute occupancy value, not a distance from either end.

Back-pressure follows simple rules. A producer must treat `full` as "not ready", and a consumer must treat `empty` as "no data valid". A push offered while `full` is high is dropped. A pop requested while `empty` is high is dropped. Both decisions are taken from the flag values present before the clock edge.

Read data always comes from a registered memory read port. The `OUT_REG` parameter can add a second output register. When that register is present, `OUT_GATE` chooses how it loads: on every cycle, or only on cycles where `rd_en` is high.

Top module: `lvl_fifo`

## Requirements
- R1: While reset is asserted, and on leaving it, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `rd_data`=0.
- R2: A push is accepted exactly when `wr_en`=1 and `full`=0. A pop is accepted exactly when `rd_en`=1 and `empty`=0. This holds even when both are requested in the same cycle, so on a full buffer only the pop is taken and on an empty buffer only the push is taken.
- R3: Accepted words leave the buffer in the order they were accepted.
- R4: `full` is 1 exactly when the occupancy equals `DEPTH`, and it is correct in the cycle after the edge that changes the occupancy.
- R5: `empty` is 1 exactly when the occupancy is 0, with the same timing as R4.
- R6: `almost_full` is 1 exactly when the occupancy is at least `AF_LEVEL`.
- R7: `almost_empty` is 1 exactly when the occupancy is at most `AE_LEVEL`.
- R8: An accepted push and an accepted pop in the same cycle leave the occupancy and all four flags unchanged.
- R9: With `OUT_REG`=0, `rd_data` shows the popped word in the cycle after the pop edge. It holds that word until the next accepted pop.
- R10: With `OUT_REG`=1 and `OUT_GATE`=0, `rd_data` loads every cycle from the read port. The popped word therefore appears two cycles after the pop edge.
- R11: With `OUT_REG`=1 and `OUT_GATE`=1, `rd_data` loads from the read port only on edges where `rd_en`=1, whether or not that pop is accepted. Otherwise it holds.
- R12: A dropped push (while full) or a dropped pop (while empty) changes neither the stored words nor the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Popped word (latency set by OUT_REG) |
| full | output | 1 | Occupancy equals DEPTH |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL |
| empty | output | 1 | Occupancy is zero |
| almost_empty | output | 1 | Occupancy at or below AE_LEVEL |

## Verification
The four flags are due in the cycle right after the edge that accepts a push or pop. Read data is due after one edge when `OUT_REG`=0 and after two edges when the output register is present. In the gated variant, data is due only after edges where `rd_en` was high. The bench drives its inputs and samples the outputs on the falling edge. It also updates its arithmetic model one rising edge ahead, so every comparison lines up with the edge that produced the result. Three copies of the block, one per read-path variant, receive identical stimulus and are compared against separately tracked expected values.

// File: rtl/lvlf_pkg.sv
package lvlf_pkg;
  // Registered status of the buffer
  typedef struct packed {
    logic full;
    logic afull;
    logic empty;
    logic aempty;
  } lvlf_flags_t;
endpackage

// File: rtl/lvlf_store.sv
module lvlf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; loads only on an accepted pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lvlf_ctrl.sv
module lvlf_ctrl
  import lvlf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 6,
  parameter int AE_LEVEL = 2,
  parameter int AW       = 3,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output lvlf_flags_t   flags
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] AFC   = CW'(AF_LEVEL);
  localparam logic [CW-1:0] AEC   = CW'(AE_LEVEL);

  logic [CW-1:0] cnt, cnt_nxt;
  lvlf_flags_t   flags_nxt;

  assign push = wr_en && !flags.full;
  assign pop  = rd_en && !flags.empty;

  always_comb begin
    cnt_nxt          = cnt + CW'(push) - CW'(pop);
    flags_nxt.full   = (cnt_nxt == FULLC);
    flags_nxt.afull  = (cnt_nxt >= AFC);
    flags_nxt.empty  = (cnt_nxt == '0);
    flags_nxt.aempty = (cnt_nxt <= AEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      flags <= '{full: 1'b0, afull: (AF_LEVEL <= 0), empty: 1'b1, aempty: 1'b1};
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt   <= cnt_nxt;
      flags <= flags_nxt;
    end
  end
endmodule

// File: rtl/lvlf_outreg.sv
module lvlf_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo
  import lvlf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 6,
  parameter int AE_LEVEL = 2,
  parameter bit OUT_REG  = 1'b0,
  parameter bit OUT_GATE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic          almost_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          push, pop;
  logic [AW-1:0] wptr, rptr;
  logic [DW-1:0] ram_q;
  lvlf_flags_t   flags;

  lvlf_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL), .AW(AW), .CW(CW))
  u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .push(push), .pop(pop), .wptr(wptr), .rptr(rptr), .flags(flags)
  );

  lvlf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push), .waddr(wptr), .wdata(wr_data),
    .re(pop), .raddr(rptr), .rdata(ram_q)
  );

  generate
    if (OUT_REG) begin : g_piped
      logic ld;
      assign ld = OUT_GATE ? rd_en : 1'b1;
      lvlf_outreg #(.DW(DW)) u_oreg (
        .clk(clk), .rst_n(rst_n), .ld(ld), .d(ram_q), .q(rd_data)
      );
    end else begin : g_direct
      assign rd_data = ram_q;
    end
  endgenerate

  assign full         = flags.full;
  assign almost_full  = flags.afull;
  assign empty        = flags.empty;
  assign almost_empty = flags.aempty;
endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic full,
  input logic almost_full,
  input logic empty,
  input logic almost_empty
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full); // R6
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full); // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty); // R12
  AST_BOTH_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !full && !empty) |=>
      $stable({full, almost_full, empty, almost_empty})); // R8
  AST_FULL_POP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_en) |=> !full); // R2
endmodule

bind lvl_fifo lvl_fifo_chk u_chk (.*);

// File: tb/lvl_fifo_bench.sv
`timescale 1ns/1ps
module lvl_fifo_bench;
  localparam int DW = 8, DEPTH = 8, AFL = 6, AEL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] q0, q1, q2;
  logic f0, af0, e0, ae0, f1, af1, e1, ae1, f2, af2, e2, ae2;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mref [DEPTH];
  int m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [DW-1:0] e_ram = '0, e_q1 = '0, e_q2 = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lvl_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .OUT_REG(1'b0), .OUT_GATE(1'b0))
  u_lvl_fifo (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(q0), .full(f0), .almost_full(af0), .empty(e0), .almost_empty(ae0));
  lvl_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .OUT_REG(1'b1), .OUT_GATE(1'b0))
  u_lvl_fifo_p (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(q1), .full(f1), .almost_full(af1), .empty(e1), .almost_empty(ae1));
  lvl_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .OUT_REG(1'b1), .OUT_GATE(1'b1))
  u_lvl_fifo_g (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(q2), .full(f2), .almost_full(af2), .empty(e2), .almost_empty(ae2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic ef, eaf, ee, eae;
    ef  = (m_cnt == DEPTH);
    eaf = (m_cnt >= AFL);
    ee  = (m_cnt == 0);
    eae = (m_cnt <= AEL);
    chk("R4 full", {29'd0, f0, f1, f2}, {29'd0, ef, ef, ef});
    chk("R5 empty", {29'd0, e0, e1, e2}, {29'd0, ee, ee, ee});
    chk("R6 almost_full", {29'd0, af0, af1, af2}, {29'd0, eaf, eaf, eaf});
    chk("R7 almost_empty", {29'd0, ae0, ae1, ae2}, {29'd0, eae, eae, eae});
    chk("R3/R9 rd_data direct", 32'(q0), 32'(e_ram));
    chk("R10 rd_data piped", 32'(q1), 32'(e_q1));
    chk("R11 rd_data gated", 32'(q2), 32'(e_q2));
  endtask

  // Called at a falling edge; model advances to the state after the next rising edge
  task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
    bit psh, pp;
    logic [DW-1:0] old_ram;
    wr_en = w; rd_en = r; wr_data = d;
    psh = w && (m_cnt != DEPTH);
    pp  = r && (m_cnt != 0);
    old_ram = e_ram;
    if (psh) begin mref[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; end
    if (pp)  begin e_ram = mref[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
    m_cnt = m_cnt + int'(psh) - int'(pp);
    e_q1 = old_ram;
    if (r) e_q2 = old_ram;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #100_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (2) @(negedge clk);
    check_all(); // R1 during reset
    chk("R1 rd_data reset", 32'(q0), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(); // R1 after release

    // Fill past full: two dropped pushes (R2, R12)
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, DW'(8'h10 + i));
    chk("R12 full after dropped pushes", {31'd0, f0}, 32'd1);
    // Both on full: pop only (R2)
    step(1'b1, 1'b1, 8'hEE);
    chk("R2 full+both drops push", {31'd0, f0}, 32'd0);
    // Both on non-full non-empty: level held (R8)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, DW'(8'h40 + i));
    chk("R8 level held", {31'd0, af0}, 32'd1);
    // Drain past empty, gated register still loads on rd_en (R11)
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 1'b1, 8'h00);
    chk("R12 empty after dropped pops", {31'd0, e0}, 32'd1);
    // Both on empty: push only (R2)
    step(1'b1, 1'b1, 8'h77);
    chk("R2 empty+both takes push", {31'd0, e0}, 32'd0);
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    chk("R2 pushed word out", 32'(q0), 32'h77);

    // Sweep every fill level with each request combination
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int op = 0; op < 4; op++) begin
        while (m_cnt < lvl) step(1'b1, 1'b0, DW'(lvl * 16 + m_cnt));
        while (m_cnt > lvl) step(1'b0, 1'b1, 8'h00);
        step(op[0], op[1], DW'(8'hA0 + op));
        step(1'b0, 1'b0, 8'h00);
      end
    end

    // Pseudo-random traffic, biased toward filling then draining
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr[7:0];
      if (i < 300) step(lfsr[9] | lfsr[8], lfsr[11] & lfsr[3], v);
      else         step(lfsr[9] & lfsr[8], lfsr[11] | lfsr[3], v);
    end
    repeat (3) step(1'b0, 1'b0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule